// File: doc/BRIEF.md
# I2C Master Control and Interrupt Registers

This block is the register front end of an I2C master. Firmware reaches it over a plain register bus: a write strobe, a read strobe, a word address and data lines. The serial engine behind it is not part of the block. The engine appears only as four event pulses, a byte-finished pulse and its two pad-drive requests. The block turns the event pulses into four sticky interrupt flags: transfer finished, data service wanted, address not acknowledged and data not acknowledged. Both not-acknowledged flags are errors. The data case means the addressed receiver refused the last byte sent to it. Each flag has an enable bit and a write-one-to-clear bit, and the enabled flags combine into one interrupt line.

The control word also holds a run bit and a software pad mode. While the run bit is 0, the engine is held idle: events are ignored, every flag and the remaining-byte counter are zeroed, and a transfer in progress is abandoned. Writing 0 to the run bit takes effect at the same clock edge. In software pad mode, two control bits drive the open-drain SCL and SDA pads directly, and the live pad levels can be read back.

A byte count register starts a message. Its remaining counter counts down on each finished byte, and a message is complete when the counter reaches zero.

Top module: `i2c_csr`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0 apart from the pad level bits, irq is 0, both pad enables are 0, and eng_run and eng_start are 0.
- R2: While run is 1, a pulse on evt_set[i] sets flag i at the next edge. Sources are 0 done, 1 service, 2 address NACK, 3 data NACK. The flags read in status bits 3:0 whatever their enables are.
- R3: irq is 1 exactly when some flag i is set and its enable, control bit 4+i, is 1.
- R4: Writing control with bit 8+i set clears flag i at that edge. A 0 in those bits has no effect, and they read back as 0.
- R5: If an event and a clear for the same flag meet in one cycle, the flag ends up set.
- R6: Control bit 0 is run. While it is 0, events are ignored and the flags and remaining count read 0. Writing 0 to it clears them at that same edge. eng_run follows the bit.
- R7: Control bit 1 selects software pad mode. In that mode scl_oe equals control bit 2 and sda_oe equals control bit 3, where 1 pulls the pad low, and the engine requests are ignored.
- R8: In engine mode each pad enable follows its engine request while run is 1, and it is 0 while run is 0.
- R9: Status bit 4 shows scl_in and status bit 5 shows sda_in.
- R10: A write to the count register (address 2) with run set and a remaining count of 0 loads the count. eng_start then pulses for one cycle if the count is nonzero. A count write while bytes remain is ignored.
- R11: Each byte_done pulse while run is 1 lowers the remaining count by one; it stops at zero. The count reads in status bits from 8 up and at address 2.
- R12: Reserved and unused bits, the clear bits and address 3 read as 0, and reserved write bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is 0 when low |
| addr | input | AW | Word address: 0 control, 1 status, 2 count |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational |
| evt_set | input | 4 | Engine event pulses, one per interrupt source |
| byte_done | input | 1 | Engine finished one byte |
| hw_scl_oe | input | 1 | Engine request to pull SCL low |
| hw_sda_oe | input | 1 | Engine request to pull SDA low |
| scl_in | input | 1 | Sampled SCL pad level |
| sda_in | input | 1 | Sampled SDA pad level |
| scl_oe | output | 1 | SCL pad pull-low enable |
| sda_oe | output | 1 | SDA pad pull-low enable |
| eng_run | output | 1 | Engine run permission |
| eng_start | output | 1 | One-cycle start pulse after a count load |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with CW=4, so the full count of 15 and the stop at zero take only a few byte pulses. AW and DW stay at 2 and 32, so all four addresses can be decoded, including the unmapped one. Writes that set every reserved bit can also be tried. A behavioural model in the bench tracks the flags, the enables, the pad mode and the counter. The bench compares irq, the pad enables, eng_run and eng_start against this model on every clock, and it checks register reads at chosen points.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;

    localparam int NSRC = 4;

    localparam int OFS_CTRL  = 0;
    localparam int OFS_STAT  = 1;
    localparam int OFS_COUNT = 2;

    localparam int CB_RUN    = 0;
    localparam int CB_CLR    = 8;
    localparam int SB_SCL_IN = 4;
    localparam int SB_SDA_IN = 5;
    localparam int SB_REM    = 8;

    // Bit i of this struct sits at control bit i
    typedef struct packed {
        logic [NSRC-1:0] ien;
        logic            sw_sda;
        logic            sw_scl;
        logic            sw_mode;
        logic            run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SRC_DONE  = 2'd0,
        SRC_SVC   = 2'd1,
        SRC_ANACK = 2'd2,
        SRC_DNACK = 2'd3
    } src_e;

    function automatic logic irq_any(input logic [NSRC-1:0] fl,
                                     input logic [NSRC-1:0] en);
        return |(fl & en);
    endfunction

endpackage

// File: rtl/i2c_csr_flags.sv
module i2c_csr_flags #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kill,
    input  logic [NS-1:0] set,
    input  logic [NS-1:0] clr,
    output logic [NS-1:0] flags
);
    for (genvar i = 0; i < NS; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || kill)
                flags[i] <= 1'b0;
            else if (set[i])
                flags[i] <= 1'b1;   // a set beats a clear in the same cycle
            else if (clr[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_csr_count.sv
module i2c_csr_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kill,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] rem,
    output logic          start
);
    localparam logic [CW-1:0] ZERO = '0;

    always_ff @(posedge clk) begin
        if (rst || kill)
            rem <= ZERO;
        else if (load)
            rem <= load_val;
        else if (dec && rem != ZERO)
            rem <= rem - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            start <= 1'b0;
        else
            start <= load && !kill && (load_val != ZERO);
    end
endmodule

// File: rtl/i2c_csr_pads.sv
module i2c_csr_pads (
    input  logic sw_mode,
    input  logic sw_scl,
    input  logic sw_sda,
    input  logic run,
    input  logic hw_scl_oe,
    input  logic hw_sda_oe,
    output logic scl_oe,
    output logic sda_oe
);
    always_comb begin
        if (sw_mode) begin
            scl_oe = sw_scl;
            sda_oe = sw_sda;
        end else begin
            scl_oe = run & hw_scl_oe;
            sda_oe = run & hw_sda_oe;
        end
    end
endmodule

// File: rtl/i2c_csr.sv
module i2c_csr
    import i2c_csr_pkg::*;
#(
    parameter int AW = 2,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    input  logic [NSRC-1:0] evt_set,
    input  logic            byte_done,
    input  logic            hw_scl_oe,
    input  logic            hw_sda_oe,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            scl_oe,
    output logic            sda_oe,
    output logic            eng_run,
    output logic            eng_start,
    output logic            irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t           ctrl_q;
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] clr_w;
    logic [NSRC-1:0] set_w;
    logic [CW-1:0]   rem_q;
    logic            ctrl_wr;
    logic            cnt_wr;
    logic            kill;
    logic            load;
    logic            unused_wdata;

    assign unused_wdata = ^wdata;

    assign ctrl_wr = wr_en && (addr == AW'(OFS_CTRL));
    assign cnt_wr  = wr_en && (addr == AW'(OFS_COUNT));

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Run low, or being written low, holds all engine state at zero
    assign kill  = !ctrl_q.run || (ctrl_wr && !wdata[CB_RUN]);
    assign clr_w = ctrl_wr ? wdata[CB_CLR +: NSRC] : '0;
    assign set_w = evt_set;
    assign load  = cnt_wr && ctrl_q.run && (rem_q == '0);

    i2c_csr_flags #(.NS(NSRC)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .kill  (kill),
        .set   (set_w),
        .clr   (clr_w),
        .flags (flags_q)
    );

    i2c_csr_count #(.CW(CW)) u_count (
        .clk      (clk),
        .rst      (rst),
        .kill     (kill),
        .load     (load),
        .load_val (wdata[CW-1:0]),
        .dec      (byte_done && ctrl_q.run),
        .rem      (rem_q),
        .start    (eng_start)
    );

    i2c_csr_pads u_pads (
        .sw_mode   (ctrl_q.sw_mode),
        .sw_scl    (ctrl_q.sw_scl),
        .sw_sda    (ctrl_q.sw_sda),
        .run       (ctrl_q.run),
        .hw_scl_oe (hw_scl_oe),
        .hw_sda_oe (hw_sda_oe),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    assign eng_run = ctrl_q.run;
    assign irq     = irq_any(flags_q, ctrl_q.ien);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == AW'(OFS_CTRL)) begin
                rdata[CTRL_W-1:0] = ctrl_q;
            end else if (addr == AW'(OFS_STAT)) begin
                rdata[NSRC-1:0]      = flags_q;
                rdata[SB_SCL_IN]     = scl_in;
                rdata[SB_SDA_IN]     = sda_in;
                rdata[SB_REM +: CW]  = rem_q;
            end else if (addr == AW'(OFS_COUNT)) begin
                rdata[CW-1:0] = rem_q;
            end
        end
    end
endmodule

// File: rtl/i2c_csr_chk.sv
module i2c_csr_chk #(
    parameter int AW = 2,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [3:0]    evt_set,
    input logic          byte_done,
    input logic          irq,
    input logic          scl_oe,
    input logic          sda_oe,
    input logic          eng_run,
    input logic          eng_start,
    input logic [3:0]    flags,
    input logic [3:0]    ien,
    input logic [CW-1:0] rem
);
    logic ctrl_wr_c;
    logic kill_c;
    assign ctrl_wr_c = wr_en && (addr == AW'(0));
    assign kill_c    = ctrl_wr_c && !wdata[0];

    assert_irq_needs_enabled_flag_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((flags & ien) != 4'd0));

    assert_off_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !eng_run |=> (flags == 4'd0 && rem == '0));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (eng_run && evt_set != 4'd0 && !kill_c) |=> ((flags & $past(evt_set)) == $past(evt_set)));

    assert_sw_pad_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_c && wdata[1]) |=> (scl_oe == $past(wdata[2]) && sda_oe == $past(wdata[3])));

    assert_count_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == AW'(2) && rem != '0 && eng_run && !byte_done) |=> (rem == $past(rem)));

    assert_start_nonzero_R10: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> (rem != '0));

    assert_decrement_R11: assert property (@(posedge clk) disable iff (rst)
        (eng_run && byte_done && rem != '0 && !ctrl_wr_c) |=> (rem == $past(rem) - CW'(1)));
endmodule

bind i2c_csr i2c_csr_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .evt_set   (evt_set),
    .byte_done (byte_done),
    .irq       (irq),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .eng_run   (eng_run),
    .eng_start (eng_start),
    .flags     (flags_q),
    .ien       (ctrl_q.ien),
    .rem       (rem_q)
);

// File: tb/i2c_csr_bench.sv
`timescale 1ns/100ps
module i2c_csr_bench;
    localparam int AW = 2;
    localparam int DW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [3:0]    evt_set = '0;
    logic          byte_done = 1'b0;
    logic          hw_scl_oe = 1'b0;
    logic          hw_sda_oe = 1'b0;
    logic          scl_in = 1'b0;
    logic          sda_in = 1'b0;
    logic          scl_oe, sda_oe, eng_run, eng_start, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    bit       m_run, m_sw, m_scl, m_sda, m_start;
    bit [3:0] m_ien, m_flags;
    int       m_rem;

    always #2.5 clk = ~clk;

    i2c_csr #(.AW(AW), .DW(DW), .CW(CW)) u_i2c_csr (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .evt_set(evt_set), .byte_done(byte_done),
        .hw_scl_oe(hw_scl_oe), .hw_sda_oe(hw_sda_oe), .scl_in(scl_in),
        .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .eng_run(eng_run),
        .eng_start(eng_start), .irq(irq)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_scl();
        return m_sw ? m_scl : (m_run & hw_scl_oe);
    endfunction
    function automatic bit exp_sda();
        return m_sw ? m_sda : (m_run & hw_sda_oe);
    endfunction

    task automatic model_step();
        bit       ctrlw, cntw, kill, load;
        bit [3:0] clr;
        bit [3:0] nf;
        int       nr;
        ctrlw = wr_en && addr == 2'd0;
        cntw  = wr_en && addr == 2'd2;
        kill  = !m_run || (ctrlw && !wdata[0]);
        clr   = ctrlw ? wdata[11:8] : 4'd0;
        nf    = kill ? 4'd0 : ((m_flags & ~clr) | evt_set);
        load  = cntw && m_run && m_rem == 0;
        if (kill) nr = 0;
        else if (load) nr = int'(wdata[3:0]);
        else if (byte_done && m_rem != 0) nr = m_rem - 1;
        else nr = m_rem;
        m_start = load && !kill && wdata[3:0] != 4'd0;
        m_flags = nf;
        m_rem   = nr;
        if (ctrlw) begin
            m_run = wdata[0]; m_sw = wdata[1]; m_scl = wdata[2];
            m_sda = wdata[3]; m_ien = wdata[7:4];
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R3 irq", irq, |(m_flags & m_ien));
        check("R8 scl_oe", scl_oe, exp_scl());
        check("R8 sda_oe", sda_oe, exp_sda());
        check("R6 eng_run", eng_run, m_run);
        check("R10 eng_start", eng_start, m_start);
        wr_en = 1'b0; evt_set = '0; byte_done = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        tick();
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        rd_en = 1'b1; addr = a;
        #0.5;
        check(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    function automatic logic [31:0] stat_exp();
        return {20'd0, 4'(m_rem), 2'b00, sda_in, scl_in, m_flags};
    endfunction

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_run = 0; m_sw = 0; m_scl = 0; m_sda = 0; m_start = 0;
        m_ien = 0; m_flags = 0; m_rem = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, 32'd0, "R1 ctrl after reset");
        rd(2'd1, 32'd0, "R1 status after reset");
        check("R1 irq", irq, 0);
        check("R1 pads", {scl_oe, sda_oe}, 0);
        check("R1 start/run", {eng_start, eng_run}, 0);

        // R2 flag set with interrupts masked
        wr(2'd0, 32'h1);
        evt_set = 4'b0001; tick();
        rd(2'd1, stat_exp(), "R2 done flag visible");
        check("R2 flag bit", rdata[0], 1);
        check("R3 masked irq low", irq, 0);

        // R3 enable all
        wr(2'd0, 32'hF1);
        check("R3 irq with enable", irq, 1);

        // R4 zero clear bits no effect, then clear
        wr(2'd0, 32'hF1);
        rd(2'd1, stat_exp(), "R4 clear zero no effect");
        check("R4 flag still set", m_flags, 4'b0001);
        wr(2'd0, 32'h1F1);
        rd(2'd1, stat_exp(), "R4 flag cleared");
        check("R4 irq after clear", irq, 0);
        rd(2'd0, 32'hF1, "R4 clear bits read zero");

        // R5 set beats clear
        evt_set = 4'b0100; wr(2'd0, 32'h4F1);
        rd(2'd1, stat_exp(), "R5 set wins");
        check("R5 flag2", m_flags[2], 1);

        // R3 only a disabled flag set
        wr(2'd0, 32'h81);
        check("R3 disabled source no irq", irq, 0);
        evt_set = 4'b1000; tick();
        check("R3 enabled data nack irq", irq, 1);

        // R6 run low clears and ignores events
        wr(2'd0, 32'h80);
        rd(2'd1, stat_exp(), "R6 flags cleared on run 0");
        evt_set = 4'b1111; tick();
        rd(2'd1, 32'd0 | stat_exp(), "R6 events ignored");
        check("R6 no flags", m_flags, 0);

        // R8 engine pads
        hw_scl_oe = 1'b1; hw_sda_oe = 1'b1; tick();
        check("R8 released while idle", {scl_oe, sda_oe}, 2'b00);
        wr(2'd0, 32'h1);
        check("R8 follow engine", {scl_oe, sda_oe}, 2'b11);
        hw_sda_oe = 1'b0; tick();

        // R7 software pads
        wr(2'd0, 32'hB);
        check("R7 sw pads scl0 sda1", {scl_oe, sda_oe}, 2'b01);
        wr(2'd0, 32'h7);
        check("R7 sw pads scl1 sda0", {scl_oe, sda_oe}, 2'b10);

        // R9 pad levels
        scl_in = 1'b1; sda_in = 1'b0;
        rd(2'd1, stat_exp(), "R9 scl level");
        scl_in = 1'b0; sda_in = 1'b1;
        rd(2'd1, stat_exp(), "R9 sda level");
        hw_scl_oe = 1'b0;
        wr(2'd0, 32'h1);

        // R10 count load and ignore while busy
        wr(2'd2, 32'd3);
        check("R10 start pulse", eng_start, 1);
        rd(2'd2, 32'd3, "R10 count loaded");
        wr(2'd2, 32'd9);
        rd(2'd2, 32'd3, "R10 busy write ignored");

        // R11 decrement and stop at zero
        for (int i = 0; i < 4; i++) begin
            byte_done = 1'b1; tick();
        end
        rd(2'd2, 32'd0, "R11 stops at zero");
        wr(2'd2, 32'd15);
        rd(2'd1, stat_exp(), "R11 full count in status");
        byte_done = 1'b1; tick();
        rd(2'd2, 32'd14, "R11 one decrement");
        wr(2'd0, 32'h0);
        rd(2'd2, 32'd0, "R6 count cleared on run 0");

        // R12 reserved and unmapped
        wr(2'd0, 32'hFFFF_F0F1);
        rd(2'd0, 32'hF1, "R12 reserved bits read zero");
        rd(2'd3, 32'd0, "R12 unmapped address");
        rd_en = 1'b0; addr = 2'd0; #0.5;
        check("R12 rdata zero without rd_en", rdata, 0);
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule